// File: doc/BRIEF.md
# Noise-Shaped Fractional Clock Divider

This block divides a fast clock by a modulus that is chosen anew for every output period. The long-run average of those moduli equals an integer part plus a binary fraction. In a frequency synthesizer it sits in the feedback path between the oscillator and the phase comparator. Once the loop has settled, the oscillator runs at the reference frequency multiplied by the average ratio. Without a fraction, the output frequency can only move in steps of the reference.

Each modulus is the integer part plus a small signed offset. A cascade of up to three first-order accumulators produces that offset. The accumulator carries are merged through a differencing network, so the offsets average to the programmed fraction while their quantization error is pushed to high frequencies. The order input sets how many stages are active. A higher order gives stronger shaping but a wider spread of instantaneous moduli.

The modulator steps once per output period. Its result is loaded into a down counter when that counter reaches zero. A divided pulse, one fast-clock cycle wide, marks every terminal count. The modulus governing the current period is visible on a port.

Top module: `fracn_divider`

## Requirements
- R1: While reset is held low, `div_pulse` is 0 and `modulus` is 0.
- R2: `div_pulse` is high for exactly one cycle per period. The number of cycles from one pulse to the next equals the `modulus` value shown during that period.
- R3: With `frac` = 0, every period's modulus equals the effective integer part, whatever the order.
- R4: With one active stage, the modulus is only ever N or N+1. With `frac` = 64 and an 8-bit accumulator, the first four periods after reset are N, N, N, N+1.
- R5: With one active stage, the first 256 moduli after reset sum to exactly 256·N + `frac`.
- R6: The modulus offset from N stays within -1..+2 with two stages and within -3..+4 with three stages.
- R7: With two or three stages, the first 256 moduli sum to 256·N + `frac` within ±2.
- R8: An integer part below 5 is treated as 5, so the modulus never falls below 2.
- R9: `modulus` changes only in the cycle right after a pulse (or at the first load after reset). It never changes mid-count.
- R10: `order` codes 0 and 1 select one stage, code 2 selects two stages and code 3 selects three stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_n | input | INT_W (8) | Integer part of the ratio |
| frac | input | ACC_W (8) | Fraction, in units of 2^-ACC_W |
| order | input | 2 | Number of active modulator stages |
| div_pulse | output | 1 | One-cycle pulse at each terminal count |
| modulus | output | INT_W+1 (9) | Modulus of the period in progress |

## Verification
A corrupted accumulator or delayed carry does not stop the output. Instead it shows up as a wrong modulus, and across 256 periods it shifts the summed moduli away from 256·N plus the fraction. With one stage that sum is exact, so a single lost carry is caught within one fraction cycle. A fault in the counter or the reload logic shows within one period, as a gap between pulses that differs from the reported modulus, or as a modulus that moves mid-count. The sweeps cover every order across fractions from zero to full scale, and also integer parts below the clamp.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  // smallest integer part; most negative offset is -3, keeps modulus >= 2
  localparam int unsigned MIN_N   = 5;
  localparam int unsigned MIN_MOD = 2;
  localparam int unsigned NSTAGE  = 3;

  typedef logic signed [3:0] ofs_t;

  // order code -> active stage count
  function automatic logic [1:0] order_to_stages(input logic [1:0] code);
    return (code < 2'd2) ? 2'd1 : code;
  endfunction
endpackage

// File: rtl/fracn_accum.sv
module fracn_accum #(
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             active,
  input  logic [ACC_W-1:0] addend,
  output logic [ACC_W-1:0] sum_nx,
  output logic             carry
);
  logic [ACC_W-1:0] sum_q, sum_d;
  logic [ACC_W:0]   total;

  always_comb begin
    total  = {1'b0, sum_q} + {1'b0, addend};
    sum_nx = total[ACC_W-1:0];
    carry  = active & total[ACC_W];
    sum_d  = sum_q;
    if (adv) sum_d = active ? total[ACC_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  // R6
  idle_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !active) |=> (sum_q == '0));
endmodule

// File: rtl/fracn_mash.sv
module fracn_mash
  import fracn_pkg::*;
#(
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [ACC_W-1:0] frac,
  input  logic [1:0]       order,
  output ofs_t             ofs
);
  logic [1:0]        n_act;
  logic [ACC_W-1:0]  sum_nx [NSTAGE];
  logic [NSTAGE-1:0] cy;
  logic              c2_q, c3_q, c3_qq;
  logic              c2_d, c3_d, c3_dd;

  assign n_act = order_to_stages(order);

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    logic [ACC_W-1:0] add_in;
    if (g == 0) begin : g_first
      assign add_in = frac;
    end else begin : g_next
      assign add_in = sum_nx[g-1];
    end
    fracn_accum #(.ACC_W(ACC_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .active (32'(g) < 32'(n_act)),
      .addend (add_in),
      .sum_nx (sum_nx[g]),
      .carry  (cy[g])
    );
  end

  // error-cancellation network: c1 + (1-z^-1)c2 + (1-z^-1)^2 c3
  always_comb begin
    ofs = $signed({3'b000, cy[0]})
        + $signed({3'b000, cy[1]}) - $signed({3'b000, c2_q})
        + $signed({3'b000, cy[2]}) - $signed({2'b00, c3_q, 1'b0})
        + $signed({3'b000, c3_qq});
    c2_d  = c2_q;
    c3_d  = c3_q;
    c3_dd = c3_qq;
    if (adv) begin
      c2_d  = cy[1];
      c3_d  = cy[2];
      c3_dd = c3_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_q  <= 1'b0;
      c3_q  <= 1'b0;
      c3_qq <= 1'b0;
    end else begin
      c2_q  <= c2_d;
      c3_q  <= c3_d;
      c3_qq <= c3_dd;
    end
  end

  // R6
  ofs_range3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (ofs >= -4'sd3 && ofs <= 4'sd4));
  // R6
  ofs_range2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && n_act == 2'd2 && $stable(order)) |-> (ofs >= -4'sd1 && ofs <= 4'sd2));
  // R4
  ofs_range1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && n_act == 2'd1 && $stable(order)) |-> (ofs == 4'sd0 || ofs == 4'sd1));
endmodule

// File: rtl/fracn_counter.sv
module fracn_counter
  import fracn_pkg::*;
#(
  parameter int MOD_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MOD_W-1:0] next_mod,
  output logic             load,
  output logic             pulse,
  output logic [MOD_W-1:0] cur_mod
);
  logic [MOD_W-1:0] cnt_q, cnt_d, mod_q, mod_d;
  logic             armed_q, armed_d;

  always_comb begin
    load    = (cnt_q == '0);
    pulse   = armed_q & load;
    cnt_d   = cnt_q - 1'b1;
    mod_d   = mod_q;
    armed_d = armed_q;
    if (load) begin
      cnt_d   = next_mod - 1'b1;
      mod_d   = next_mod;
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      mod_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      mod_q   <= mod_d;
      armed_q <= armed_d;
    end
  end

  assign cur_mod = mod_q;

  // R9
  mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mod_q));
  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  // R8
  mod_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (mod_q >= MOD_W'(MIN_MOD)));
endmodule

// File: rtl/fracn_divider.sv
module fracn_divider
  import fracn_pkg::*;
#(
  parameter int INT_W = 8,
  parameter int ACC_W = 8,
  localparam int MOD_W = INT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INT_W-1:0] int_n,
  input  logic [ACC_W-1:0] frac,
  input  logic [1:0]       order,
  output logic             div_pulse,
  output logic [MOD_W-1:0] modulus
);
  logic [1:0]         rsync_q;
  logic               rst_ni;
  logic [INT_W-1:0]   n_eff;
  ofs_t               ofs;
  logic signed [MOD_W:0] mod_s;
  logic [MOD_W-1:0]   next_mod;
  logic               load;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  always_comb begin
    n_eff    = (int_n < INT_W'(MIN_N)) ? INT_W'(MIN_N) : int_n;
    mod_s    = $signed({2'b00, n_eff}) + {{(MOD_W-3){ofs[3]}}, ofs};
    next_mod = mod_s[MOD_W-1:0];
  end

  fracn_mash #(.ACC_W(ACC_W)) u_mash (
    .clk   (clk),
    .rst_n (rst_ni),
    .adv   (load),
    .frac  (frac),
    .order (order),
    .ofs   (ofs)
  );

  fracn_counter #(.MOD_W(MOD_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_ni),
    .next_mod (next_mod),
    .load     (load),
    .pulse    (div_pulse),
    .cur_mod  (modulus)
  );

  // R8
  next_floor_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    load |-> (next_mod >= MOD_W'(MIN_MOD)));
endmodule

// File: tb/fracn_divider_tb.sv
module fracn_divider_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] int_n = 8'd6;
  logic [7:0] frac = 8'd0;
  logic [1:0] order = 2'd1;
  logic       div_pulse;
  logic [8:0] modulus;

  int checks = 0, errors = 0, cycles = 0;
  int pulses, cyc_since, sum_mod, min_mod, max_mod, bad_len, bad_width, bad_hold;
  int seq [4];
  int last_mod;
  logic prev_pulse;

  always #2 clk = ~clk;

  fracn_divider u_dut (
    .clk(clk), .rst_n(rst_n), .int_n(int_n), .frac(frac),
    .order(order), .div_pulse(div_pulse), .modulus(modulus)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (pulses > 0 && !prev_pulse && int'(modulus) != last_mod) bad_hold++;
      if (div_pulse) begin
        if (pulses > 0 && cyc_since != int'(modulus)) bad_len++;
        if (prev_pulse) bad_width++;
        if (pulses < 256) begin
          sum_mod += int'(modulus);
          if (int'(modulus) < min_mod) min_mod = int'(modulus);
          if (int'(modulus) > max_mod) max_mod = int'(modulus);
        end
        if (pulses < 4) seq[pulses] = int'(modulus);
        pulses++;
        cyc_since = 1;
      end else begin
        cyc_since++;
      end
      prev_pulse = div_pulse;
      last_mod   = int'(modulus);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_cfg(input int n, input int f, input int m);
    @(negedge clk);
    rst_n = 1'b0;
    int_n = 8'(n);
    frac  = 8'(f);
    order = 2'(m);
    pulses = 0; cyc_since = 0; sum_mod = 0; min_mod = 1000; max_mod = -1;
    bad_len = 0; bad_width = 0; bad_hold = 0; prev_pulse = 1'b0; last_mod = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    while (pulses < 257) @(negedge clk);
  endtask

  function automatic int eff_n(input int n);
    return (n < 5) ? 5 : n;
  endfunction

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(div_pulse == 1'b0, "R1 pulse in reset", int'(div_pulse), 0);
    check(modulus == 9'd0, "R1 modulus in reset", int'(modulus), 0);

    for (int m = 1; m <= 3; m++) begin
      for (int k = 0; k < 7; k++) begin
        int f, lo, hi, ne, dev;
        case (k)
          0: f = 0;   1: f = 1;   2: f = 64;  3: f = 85;
          4: f = 128; 5: f = 200; default: f = 255;
        endcase
        run_cfg(6, f, m);
        ne = eff_n(6);
        check(bad_len == 0, "R2 period vs modulus", bad_len, 0);
        check(bad_width == 0, "R2 pulse width", bad_width, 0);
        check(bad_hold == 0, "R9 modulus hold", bad_hold, 0);
        lo = (m == 1) ? 0 : (m == 2) ? -1 : -3;
        hi = (m == 1) ? 1 : (m == 2) ? 2 : 4;
        check(min_mod - ne >= lo, "R6/R4 low offset", min_mod - ne, lo);
        check(max_mod - ne <= hi, "R6/R4 high offset", max_mod - ne, hi);
        if (f == 0) begin
          check(min_mod == ne && max_mod == ne, "R3 zero fraction", max_mod, ne);
        end
        dev = sum_mod - 256 * ne - f;
        if (m == 1) check(dev == 0, "R5 exact average", sum_mod, 256 * ne + f);
        else        check(dev >= -2 && dev <= 2, "R7 average", sum_mod, 256 * ne + f);
      end
    end

    // R4 / R10: quarter fraction pattern, order codes 0 and 1
    for (int m = 0; m <= 1; m++) begin
      run_cfg(9, 64, m);
      check(seq[0] == 9, "R4 R10 step 1", seq[0], 9);
      check(seq[1] == 9, "R4 R10 step 2", seq[1], 9);
      check(seq[2] == 9, "R4 R10 step 3", seq[2], 9);
      check(seq[3] == 10, "R4 R10 step 4", seq[3], 10);
      check(sum_mod == 256 * 9 + 64, "R10 one stage sum", sum_mod, 256 * 9 + 64);
    end

    // R10: code 3 spreads wider than code 2 for a mid fraction
    run_cfg(20, 85, 3);
    check(max_mod - min_mod > 3, "R10 three-stage spread", max_mod - min_mod, 4);

    // R8: clamp of small integer parts
    run_cfg(2, 0, 3);
    check(min_mod == 5 && max_mod == 5, "R8 clamp to 5", min_mod, 5);
    run_cfg(0, 255, 3);
    check(min_mod >= 2, "R8 floor with three stages", min_mod, 2);
    check(bad_len == 0, "R8 R2 short periods", bad_len, 0);
    run_cfg(4, 128, 1);
    check(sum_mod == 256 * 5 + 128, "R8 clamp sum", sum_mod, 256 * 5 + 128);

    // R1: reset again after activity
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(div_pulse == 1'b0 && modulus == 9'd0, "R1 re-reset", int'(modulus), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule